// File: doc/BRIEF.md
# Gate Transition Sequencer with Dead Time

This block drives a group of power-switch gate lines, for instance twelve gates covering three full-bridge cells. It takes a new target gate word and applies it in two steps, so that two switches in one leg are never on together. First it opens every gate that is on now and must end up off. Then it waits a dead time that software sets in clock ticks. After that it closes every gate that must end up on. Gates whose value is the same in the old and new words are left alone for the whole sequence.

Each request first passes through a fixed delay line. This lines it up with the read latency of the lookup memory that produced the word. A request that arrives while a transition is still running waits in a single slot. It starts on the clock edge after the running turn-on step. A busy output reports that work is still outstanding. At a 25 MHz clock, one dead-time tick is 40 ns.

Top module: `gate_seq`

## Requirements
- R1: While reset is asserted and on the first edge after it, `gateWord` is all zeros and `busy` is low.
- R2: A request sampled on clock edge E (`loadStb` high) makes its turn-off step on edge E+LAT (default LAT = 3), provided the sequencer is idle then. On that edge every bit that is 1 in `gateWord` and 0 in `targetWord` becomes 0, and no bit goes from 0 to 1.
- R3: The turn-on step comes D edges after the turn-off step. D is the `deadTicks` value sampled with the request. On that edge `gateWord` equals the requested word, and until then no bit rises.
- R4: A bit that has the same value in the old and the requested word does not change on any edge of the transition.
- R5: A `deadTicks` value of 0 acts as 1, so the turn-on step comes exactly one edge after the turn-off step.
- R6: A request that reaches the end of the delay line while a transition is running is held. Its turn-off step happens on the edge right after the running turn-on step.
- R7: At most one request waits. A later request that reaches the waiting slot replaces the one already there, and the replaced word is never applied.
- R8: `busy` is high from the edge that samples a request until the edge of the last outstanding turn-on step, and it is low after that edge if nothing else is pending. While `busy` is low, `gateWord` does not change on the next edge.
- R9: No edge both raises one gate bit and lowers another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick is the dead-time unit |
| rst_n | input | 1 | Active-low synchronous reset |
| loadStb | input | 1 | Request strobe, sampled on the rising edge |
| targetWord | input | GATES | Requested gate word (1 = gate on) |
| deadTicks | input | DEAD_W | Dead time in clock ticks, sampled with the strobe |
| gateWord | output | GATES | Gate drive word |
| busy | output | 1 | Request in the delay line, waiting, or in transition |

## Verification
The bench sends requests close together. One arrives during a long dead time and must wait. In another case three arrive in a row and the middle one must be dropped. A sequencer that took a waiting request straight away would overlap two transitions. One that kept the oldest waiting word would apply 0x111 where 0x222 is expected. A dead time of zero is sent as well: a design that did not clamp it would either turn on in the same cycle as the turn-off or count down through the full counter range. Words that overlap the present state check that shared bits never glitch. A per-edge check also catches any edge that raises and lowers gates together, which would allow shoot-through in a leg.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

  // strobes from the sequencing control to the gate datapath
  typedef struct packed {
    logic startOff;   // latch candidate, open gates that must turn off
    logic applyOn;    // drive the full latched word
  } seq_strobes_t;

endpackage

// File: rtl/gate_seq_datapath.sv
module gate_seq_datapath
  import gate_seq_pkg::*;
#(
  parameter int GATES  = 12,
  parameter int DEAD_W = 8,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadStb,
  input  logic [GATES-1:0]  targetWord,
  input  logic [DEAD_W-1:0] deadTicks,
  input  seq_strobes_t      strobes,
  output logic              candValid,
  output logic [DEAD_W-1:0] candDead,
  output logic              pendBusy,
  output logic [GATES-1:0]  gateWord
);

  localparam int LAST = LAT - 1;

  logic [LAT-1:0]    stValid;
  logic [GATES-1:0]  stWord [LAT];
  logic [DEAD_W-1:0] stDead [LAT];

  // latency alignment line
  for (genvar i = 0; i < LAT; i++) begin : g_stage
    logic              inValid;
    logic [GATES-1:0]  inWord;
    logic [DEAD_W-1:0] inDead;
    if (i == 0) begin : g_head
      assign inValid = loadStb;
      assign inWord  = targetWord;
      assign inDead  = deadTicks;
    end else begin : g_body
      assign inValid = stValid[i-1];
      assign inWord  = stWord[i-1];
      assign inDead  = stDead[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stValid[i] <= 1'b0;
        stWord[i]  <= '0;
        stDead[i]  <= '0;
      end else begin
        stValid[i] <= inValid;
        stWord[i]  <= inWord;
        stDead[i]  <= inDead;
      end
    end
  end

  logic              pipeValid;
  logic              holdValid;
  logic [GATES-1:0]  holdWord;
  logic [DEAD_W-1:0] holdDead;
  logic [GATES-1:0]  nextWord;
  logic [GATES-1:0]  candWord;
  logic              takePipe;

  assign pipeValid = stValid[LAST];
  assign candValid = holdValid | pipeValid;
  assign candWord  = holdValid ? holdWord : stWord[LAST];
  assign candDead  = holdValid ? holdDead : stDead[LAST];
  assign takePipe  = strobes.startOff & ~holdValid;
  assign pendBusy  = (|stValid) | holdValid;

  // single waiting slot, newest request wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdValid <= 1'b0;
      holdWord  <= '0;
      holdDead  <= '0;
    end else if (pipeValid && !takePipe) begin
      holdValid <= 1'b1;
      holdWord  <= stWord[LAST];
      holdDead  <= stDead[LAST];
    end else if (strobes.startOff) begin
      holdValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gateWord <= '0;
      nextWord <= '0;
    end else if (strobes.startOff) begin
      nextWord <= candWord;
      gateWord <= gateWord & candWord;
    end else if (strobes.applyOn) begin
      gateWord <= nextWord;
    end
  end

endmodule

// File: rtl/gate_seq_control.sv
module gate_seq_control
  import gate_seq_pkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              candValid,
  input  logic [DEAD_W-1:0] candDead,
  output seq_strobes_t      strobes,
  output logic              inTransition
);

  typedef enum logic {ST_IDLE, ST_DEAD} seq_state_t;

  localparam logic [DEAD_W-1:0] ONE_TICK = DEAD_W'(1);

  seq_state_t        state;
  logic [DEAD_W-1:0] tickCnt;
  logic [DEAD_W-1:0] loadCnt;

  assign loadCnt          = (candDead == '0) ? ONE_TICK : candDead;
  assign strobes.startOff = (state == ST_IDLE) && candValid;
  assign strobes.applyOn  = (state == ST_DEAD) && (tickCnt == ONE_TICK);
  assign inTransition     = (state == ST_DEAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (strobes.startOff) begin
          state   <= ST_DEAD;
          tickCnt <= loadCnt;
        end
        ST_DEAD: if (strobes.applyOn) state <= ST_IDLE;
                 else                 tickCnt <= tickCnt - ONE_TICK;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gate_seq.sv
module gate_seq
  import gate_seq_pkg::*;
#(
  parameter int GATES  = 12,
  parameter int DEAD_W = 8,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadStb,
  input  logic [GATES-1:0]  targetWord,
  input  logic [DEAD_W-1:0] deadTicks,
  output logic [GATES-1:0]  gateWord,
  output logic              busy
);

  seq_strobes_t      strobes;
  logic              candValid;
  logic [DEAD_W-1:0] candDead;
  logic              pendBusy;
  logic              inTransition;

  gate_seq_datapath #(.GATES(GATES), .DEAD_W(DEAD_W), .LAT(LAT)) u_dp (
    .clk(clk), .rst_n(rst_n), .loadStb(loadStb), .targetWord(targetWord),
    .deadTicks(deadTicks), .strobes(strobes), .candValid(candValid),
    .candDead(candDead), .pendBusy(pendBusy), .gateWord(gateWord)
  );

  gate_seq_control #(.DEAD_W(DEAD_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .candValid(candValid), .candDead(candDead),
    .strobes(strobes), .inTransition(inTransition)
  );

  assign busy = pendBusy | inTransition;

endmodule

// File: rtl/gate_seq_checker.sv
module gate_seq_checker #(
  parameter int GATES = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [GATES-1:0] gateWord,
  input logic             busy
);

  AST_RESET_OFF: assert property (@(posedge clk)
    $rose(rst_n) |-> (gateWord == '0 && !busy)); // R1

  AST_NO_MIXED_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((gateWord & ~$past(gateWord)) == '0) ||
    ((~gateWord & $past(gateWord)) == '0)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(gateWord)); // R8

  AST_RISE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((gateWord & ~$past(gateWord)) != '0) |-> $past(busy)); // R3

endmodule

bind gate_seq gate_seq_checker #(.GATES(GATES)) u_chk (
  .clk(clk), .rst_n(rst_n), .gateWord(gateWord), .busy(busy)
);

// File: tb/gate_seq_test.sv
module gate_seq_test;
  localparam int GATES = 12, DEAD_W = 8, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0, loadStb = 1'b0;
  logic [GATES-1:0]  targetWord = '0;
  logic [DEAD_W-1:0] deadTicks = '0;
  logic [GATES-1:0]  gateWord;
  logic              busy;

  gate_seq #(.GATES(GATES), .DEAD_W(DEAD_W), .LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .loadStb(loadStb), .targetWord(targetWord),
    .deadTicks(deadTicks), .gateWord(gateWord), .busy(busy)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference
  logic [GATES-1:0] mGates = '0, mTarget = '0, mHoldWord = '0, prevGates = '0;
  bit mHold = 0, mIdle = 1;
  int mCnt = 0, mHoldDead = 0, cyc = 0;
  logic [GATES-1:0] qWord[$];
  int qDead[$];
  int qDue[$];

  task automatic mStart(logic [GATES-1:0] w, int d);
    mTarget = w;
    mGates  = mGates & w;
    mCnt    = (d == 0) ? 1 : d;
    mIdle   = 0;
  endtask

  always @(posedge clk) begin
    bit arr;
    logic [GATES-1:0] aw;
    int ad;
    arr = 0; aw = '0; ad = 0;
    if (!rst_n) begin
      mGates = '0; mHold = 0; mIdle = 1; mCnt = 0;
      qWord.delete(); qDead.delete(); qDue.delete();
    end else begin
      if (qDue.size() > 0 && qDue[0] == cyc) begin
        arr = 1; aw = qWord.pop_front(); ad = qDead.pop_front();
        void'(qDue.pop_front());
      end
      if (mIdle) begin
        if (mHold) begin
          mStart(mHoldWord, mHoldDead);
          mHold = arr; mHoldWord = aw; mHoldDead = ad;
        end else if (arr) mStart(aw, ad);
      end else begin
        if (mCnt == 1) begin mGates = mTarget; mIdle = 1; end
        else mCnt--;
        if (arr) begin mHold = 1; mHoldWord = aw; mHoldDead = ad; end
      end
      if (loadStb) begin
        qWord.push_back(targetWord); qDead.push_back(int'(deadTicks));
        qDue.push_back(cyc + LAT);
      end
    end
    cyc++;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 R3 model gateWord", 32'(gateWord), 32'(mGates));
      check("R8 model busy", 32'(busy),
            32'(qDue.size() > 0 || mHold || !mIdle));
      check("R9 mixed edge", 32'(((gateWord & ~prevGates) != '0) &&
                                 ((~gateWord & prevGates) != '0)), 32'd0);
    end
    prevGates = gateWord;
  end

  task automatic load(logic [GATES-1:0] w, logic [DEAD_W-1:0] d);
    targetWord = w; deadTicks = d; loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset gateWord", 32'(gateWord), 32'd0);
    check("R1 reset busy", 32'(busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 32'(gateWord), 32'd0);

    // R2/R3: from all-off, dead 4
    load(12'hF0F, 8'd4);
    waitN(3); check("R2 no rise on off edge", 32'(gateWord), 32'h000);
    waitN(3); check("R3 held during dead time", 32'(gateWord), 32'h000);
    waitN(1); check("R3 turn-on edge", 32'(gateWord), 32'hF0F);
    waitIdle();

    // R4: overlapping words, dead 2
    load(12'h0FF, 8'd2);
    check("R8 busy after strobe", 32'(busy), 32'd1);
    waitN(3); check("R2 turn-off only", 32'(gateWord), 32'h00F);
    waitN(1); check("R4 shared bits steady", 32'(gateWord), 32'h00F);
    waitN(1); check("R3 turn-on dead 2", 32'(gateWord), 32'h0FF);
    check("R8 busy drops", 32'(busy), 32'd0);
    waitIdle();

    // R5: zero dead time
    load(12'hF00, 8'd0);
    waitN(3); check("R5 off step", 32'(gateWord), 32'h000);
    waitN(1); check("R5 on one tick later", 32'(gateWord), 32'hF00);
    waitIdle();

    // R6: second request during dead time
    load(12'h00F, 8'd6);
    load(12'hFF0, 8'd1);
    waitN(8); check("R6 first turn-on", 32'(gateWord), 32'h00F);
    waitN(1); check("R6 held off step", 32'(gateWord), 32'h000);
    waitN(1); check("R6 held on step", 32'(gateWord), 32'hFF0);
    waitIdle();

    // R7: newest waiting request replaces older one
    load(12'h0F0, 8'd8);
    load(12'h111, 8'd1);
    load(12'h222, 8'd1);
    waitN(10); check("R7 newest off step", 32'(gateWord), 32'h020);
    check("R8 busy while pending", 32'(busy), 32'd1);
    waitN(1); check("R7 newest applied", 32'(gateWord), 32'h222);
    waitIdle();

    // random traffic against the reference
    for (int i = 0; i < 400; i++) begin
      loadStb    = ($urandom % 5) == 0;
      targetWord = GATES'($urandom);
      deadTicks  = DEAD_W'($urandom % 6);
      @(negedge clk);
    end
    loadStb = 1'b0;
    waitIdle();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=idle");
      finishRun();
    end
  end

endmodule